// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire Ethernet PHY management interface. Software programs a clock divider, then writes one 32-bit command word. That word already holds the whole frame body: start code, opcode, PHY address, register address, turnaround bits and 16 data bits. The block sends a 32-bit preamble of ones and then shifts the command word out, most significant bit first. It drives MDC from the divider and handles the output enable of the bidirectional MDIO line.

When the command is a read, the block releases MDIO for the PHY's turnaround bit and for the data phase. It shifts in the 16 bits the PHY returns and places them in the low half of the command register. The upper half of that register keeps the upper half of the command. Each finished frame sets a sticky done event, which software clears by writing a one to it. A busy flag shows that a frame is in flight.

The frame sequencer runs through five named states. ST_IDLE goes to ST_PREAMBLE when a command is accepted ("launch"). ST_PREAMBLE goes to ST_ADDR after the 32nd preamble bit ("preamble_done"). ST_ADDR goes to ST_TURN after the 14 start, opcode and address bits ("header_done"). ST_TURN goes to ST_DATA after the two turnaround bits ("turn_done"). ST_DATA goes back to ST_IDLE after the 16th data bit ("frame_done"). Every bit advance happens on an MDC falling edge.

Top module: `mdio_master`

## Requirements
- R1: After reset, the command register (select 0), the divider register (select 1) and the event register (select 2) all read 0. MDC and the MDIO output enable are low.
- R2: An accepted command produces 64 bits on MDIO, one per MDC period: 32 ones, then command bits 31 down to 0. Each bit changes only after an MDC falling edge and is stable at the following rising edge.
- R3: The divider field D sits in bits [DIV_W:1] of the divider register, and bit 0 reads as 0. During a frame, MDC has a period of 2*D system clocks.
- R4: While D is 0, MDC stays low and a command write starts no frame, so the busy bit stays 0.
- R5: When command bits [29:28] equal 2'b10 (read), the output enable is low at the MDC rising edges of bit 47 (second turnaround bit) through bit 63. The 16 bits sampled on those rising edges for bits 48..63 replace command register bits [15:0], MSB first. Bits [31:16] stay unchanged.
- R6: With any other opcode (for example 2'b01, write), the output enable is high for all 64 bits and the command register keeps the written word.
- R7: Bit 0 of the event register is set when a frame ends and stays set. Writing a 1 to bit 0 clears it; writing a 0 leaves it set.
- R8: Bit 1 of the event register (busy) is high from command acceptance until the frame ends. A command write while busy is ignored, both in what is sent and in the register contents.
- R9: Between frames, MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 command, 1 divider, 2 event |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = block drives the line) |
| mdio_i | input | 1 | MDIO line value as seen by the block |

## Verification
The bench builds the block with the default 6-bit divider field, so it can reach both the smallest divider of 1 and the largest of 63. This lets it measure MDC at two system clocks per period and at 126. The bench also contains a PHY responder that returns data only during read frames. This exposes the turnaround release point, any line contention and the capture order. Patterns of all ones, all zeros and a single set bit at either end test the bit order of the returned data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    // Frame geometry, in MDIO bit periods
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 14;
    localparam int TA_BITS    = 2;
    localparam int DAT_BITS   = 16;
    localparam int WORD_BITS  = HDR_BITS + TA_BITS + DAT_BITS;
    localparam int FRAME_BITS = PRE_BITS + WORD_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    // Opcode field position within the command word and the read code
    localparam int OP_MSB = WORD_BITS - 3;
    localparam logic [1:0] OP_READ = 2'b10;

    // Register selects
    localparam logic [1:0] SEL_CMD = 2'd0;
    localparam logic [1:0] SEL_DIV = 2'd1;
    localparam logic [1:0] SEL_EVT = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_ADDR,
        ST_TURN,
        ST_DATA
    } mdio_state_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_m1;
    logic             active;
    logic             terminal;

    assign div_m1   = div - 1'b1;
    assign active   = run && (div != '0);
    assign terminal = active && (cnt_q == div_m1);
    assign rise_evt = terminal && !mdc;
    assign fall_evt = terminal && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!active) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (terminal) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WORD_BITS-1:0] word,
    input  logic                 rise_evt,
    input  logic                 fall_evt,
    input  logic                 mdio_i,
    output mdio_state_e          state,
    output logic                 busy,
    output logic                 finish,
    output logic                 is_read,
    output logic [DAT_BITS-1:0]  rd_data,
    output logic                 mdio_o,
    output logic                 mdio_oe
);
    localparam logic [IDX_W-1:0] PRE_END    = IDX_W'(PRE_BITS - 1);
    localparam logic [IDX_W-1:0] ADDR_END   = IDX_W'(PRE_BITS + HDR_BITS - 1);
    localparam logic [IDX_W-1:0] TURN_END   = IDX_W'(PRE_BITS + HDR_BITS + TA_BITS - 1);
    localparam logic [IDX_W-1:0] DATA_END   = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_RELEASE = IDX_W'(PRE_BITS + HDR_BITS + 1);

    mdio_state_e               state_q, state_d;
    logic [IDX_W-1:0]          idx_q;
    logic [FRAME_BITS-1:0]     sh_q;
    logic [DAT_BITS-1:0]       rd_q;
    logic                      rd_op_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)                           state_d = ST_PREAMBLE; // launch
            ST_PREAMBLE: if (fall_evt && idx_q == PRE_END)    state_d = ST_ADDR;     // preamble_done
            ST_ADDR:     if (fall_evt && idx_q == ADDR_END)   state_d = ST_TURN;     // header_done
            ST_TURN:     if (fall_evt && idx_q == TURN_END)   state_d = ST_DATA;     // turn_done
            ST_DATA:     if (fall_evt && idx_q == DATA_END)   state_d = ST_IDLE;     // frame_done
            default:                                          state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shift and bit-count datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            idx_q   <= '0;
            rd_op_q <= 1'b0;
            rd_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                sh_q    <= {{PRE_BITS{1'b1}}, word};
                idx_q   <= '0;
                rd_op_q <= (word[OP_MSB -: 2] == OP_READ);
            end else if (state_q != ST_IDLE && fall_evt) begin
                sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == ST_DATA && rise_evt) begin
                rd_q <= {rd_q[DAT_BITS-2:0], mdio_i};
            end
        end
    end

    // Output logic
    always_comb begin
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:     mdio_oe = 1'b0;
            ST_PREAMBLE: mdio_oe = 1'b1;
            ST_ADDR:     mdio_oe = 1'b1;
            ST_TURN:     mdio_oe = !(rd_op_q && idx_q == TA_RELEASE);
            ST_DATA:     mdio_oe = !rd_op_q;
            default:     mdio_oe = 1'b0;
        endcase
        mdio_o  = mdio_oe & sh_q[FRAME_BITS-1];
        busy    = (state_q != ST_IDLE);
        finish  = (state_q == ST_DATA) && fall_evt && (idx_q == DATA_END);
        is_read = rd_op_q;
        rd_data = rd_q;
        state   = state_q;
    end
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           reg_sel,
    input  logic                 reg_we,
    input  logic [WORD_BITS-1:0] reg_wdata,
    output logic [WORD_BITS-1:0] reg_rdata,
    input  logic                 busy,
    input  logic                 finish,
    input  logic                 is_read,
    input  logic [DAT_BITS-1:0]  rd_data,
    output logic [DIV_W-1:0]     div,
    output logic                 start,
    output logic [WORD_BITS-1:0] cmd,
    output logic                 done
);
    localparam int DIV_PAD = WORD_BITS - DIV_W - 1;

    logic cmd_wr;
    logic evt_clr;

    assign cmd_wr  = reg_we && (reg_sel == SEL_CMD) && !busy;
    assign start   = cmd_wr && (div != '0);
    assign evt_clr = reg_we && (reg_sel == SEL_EVT) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd  <= '0;
            div  <= '0;
            done <= 1'b0;
        end else begin
            if (cmd_wr) begin
                cmd <= reg_wdata;
            end else if (finish && is_read) begin
                cmd[DAT_BITS-1:0] <= rd_data;
            end
            if (reg_we && reg_sel == SEL_DIV) begin
                div <= reg_wdata[DIV_W:1];
            end
            if (finish)       done <= 1'b1;
            else if (evt_clr) done <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CMD: reg_rdata = cmd;
            SEL_DIV: reg_rdata = {{DIV_PAD{1'b0}}, div, 1'b0};
            SEL_EVT: reg_rdata = {{(WORD_BITS-2){1'b0}}, busy, done};
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_sel,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [DIV_W-1:0]     div;
    logic                 start;
    logic                 busy;
    logic                 finish;
    logic                 is_read;
    logic                 done;
    logic                 rise_evt;
    logic                 fall_evt;
    logic [DAT_BITS-1:0]  rd_data;
    logic [WORD_BITS-1:0] cmd;
    mdio_state_e          state;

    mdio_regfile #(.DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .finish    (finish),
        .is_read   (is_read),
        .rd_data   (rd_data),
        .div       (div),
        .start     (start),
        .cmd       (cmd),
        .done      (done)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div      (div),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .word     (reg_wdata),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .state    (state),
        .busy     (busy),
        .finish   (finish),
        .is_read  (is_read),
        .rd_data  (rd_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mdc,
    input logic             mdio_oe,
    input logic [DIV_W-1:0] div,
    input logic             done,
    input logic [15:0]      cmd_hi,
    input logic             reg_we,
    input logic [1:0]       reg_sel,
    input logic             clr_bit,
    input mdio_state_e      state,
    input logic             is_read
);
    // R4
    div_zero_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |=> !mdc);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R7
    done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_EVT && clr_bit && !busy) |=> !done);

    // R8
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_sel == SEL_CMD) |=> $stable(cmd_hi));

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && is_read) |-> !mdio_oe);

    // R6
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_read) |-> mdio_oe);
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .mdc     (mdc),
    .mdio_oe (mdio_oe),
    .div     (div),
    .done    (done),
    .cmd_hi  (cmd[31:16]),
    .reg_we  (reg_we),
    .reg_sel (reg_sel),
    .clr_bit (reg_wdata[0]),
    .state   (state),
    .is_read (is_read)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        line;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // PHY responder state
    int          rise_tot = 0;
    int          base = 0;
    int          cyc = 0;
    int          last_rise = 0;
    int          gap = 0;
    int          oe_bad = 0;
    int          contend = 0;
    logic        bench_read = 1'b0;
    logic [15:0] phy_data = 16'h0;
    logic        phy_en = 1'b0;
    logic        phy_bit = 1'b1;
    logic [63:0] cap = 64'h0;

    assign line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge mdc) begin
        int i;
        i = rise_tot - base;
        cap <= {cap[62:0], line};
        gap <= cyc - last_rise;
        last_rise <= cyc;
        if (bench_read && i >= 47 && i <= 63) begin
            if (mdio_oe) oe_bad <= oe_bad + 1;
        end else if (i >= 0 && i <= 63) begin
            if (!mdio_oe) oe_bad <= oe_bad + 1;
        end
        if (mdio_oe && phy_en) contend <= contend + 1;
        rise_tot <= rise_tot + 1;
    end

    always @(negedge mdc) begin
        int i;
        i = rise_tot - base;
        phy_en  <= bench_read && i >= 47 && i <= 63;
        phy_bit <= (i >= 48 && i <= 63) ? phy_data[63-i] : 1'b0;
    end

    // stimulus table: {divider, command word, PHY response}
    localparam logic [53:0] VEC [5] = '{
        {6'd1,  32'h608A0000, 16'hA5C3},
        {6'd3,  32'h5192BEEF, 16'h0000},
        {6'd2,  32'h6FFE1234, 16'hFFFF},
        {6'd5,  32'h50020001, 16'h8001},
        {6'd63, 32'h608A0000, 16'h0001}
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] e;
        ok = 0;
        for (int k = 0; k < 20000; k++) begin
            rd(2'd2, e);
            if (e[0] && !e[1]) begin ok = 1; break; end
        end
    endtask

    task automatic arm(logic rdop, logic [15:0] pd);
        @(negedge clk);
        base = rise_tot;
        bench_read = rdop;
        phy_data = pd;
        oe_bad = 0;
        contend = 0;
    endtask

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 cmd", 64'(v), 64'h0);
        rd(2'd1, v); check("R1 div", 64'(v), 64'h0);
        rd(2'd2, v); check("R1 evt", 64'(v), 64'h0);
        check("R1 mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);

        // R4 zero divider blocks frames
        begin
            int r0;
            r0 = rise_tot;
            wr(2'd0, 32'h608A0000);
            rd(2'd2, v); check("R4 no busy", 64'(v[1]), 64'h0);
            repeat (50) @(negedge clk);
            check("R4 mdc idle", 64'(rise_tot - r0), 64'h0);
        end

        // R3 divider field placement
        wr(2'd1, 32'hFFFFFFFF);
        rd(2'd1, v); check("R3 div readback", 64'(v), 64'h7E);

        // table of frames
        for (int n = 0; n < 5; n++) begin
            logic [5:0]  d;
            logic [31:0] c;
            logic [15:0] p;
            logic        r;
            {d, c, p} = VEC[n];
            r = (c[29:28] == 2'b10);
            wr(2'd2, 32'h1);
            wr(2'd1, {25'h0, d, 1'b0});
            arm(r, p);
            wr(2'd0, c);
            wait_done(ok);
            check("R7 done set", 64'(ok), 64'h1);
            check("R3 mdc period", 64'(gap), 64'(2 * d));
            if (r) begin
                check("R2/R5 frame bits", cap, {32'hFFFFFFFF, c[31:17], 1'b0, p});
                rd(2'd0, v); check("R5 read data", 64'(v), {32'h0, c[31:16], p});
                check("R5 oe release", 64'(oe_bad), 64'h0);
                check("R5 no contention", 64'(contend), 64'h0);
            end else begin
                check("R2/R6 frame bits", cap, {32'hFFFFFFFF, c});
                rd(2'd0, v); check("R6 data kept", 64'(v), 64'(c));
                check("R6 oe driven", 64'(oe_bad), 64'h0);
            end
            check("R9 idle", {62'h0, mdc, mdio_oe}, 64'h0);
        end

        // R7 sticky, write-0 no effect, write-1 clears
        wr(2'd2, 32'h0);
        rd(2'd2, v); check("R7 sticky", 64'(v[0]), 64'h1);
        wr(2'd2, 32'h1);
        rd(2'd2, v); check("R7 cleared", 64'(v[0]), 64'h0);

        // R8 busy and ignored command write
        wr(2'd1, 32'h4);
        arm(1'b1, 16'h3C5A);
        wr(2'd0, 32'h608A0000);
        repeat (20) @(negedge clk);
        rd(2'd2, v); check("R8 busy", 64'(v[1]), 64'h1);
        wr(2'd0, 32'h5192BEEF);
        wait_done(ok);
        check("R8 frame done", 64'(ok), 64'h1);
        rd(2'd0, v); check("R8 write ignored", 64'(v), 64'h608A3C5A);
        check("R8 frame unaffected", cap, {32'hFFFFFFFF, 15'h3045, 1'b0, 16'h3C5A});
        check("R9 idle after", {62'h0, mdc, mdio_oe}, 64'h0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule